// File: doc/BRIEF.md
# Single-Slope Pulse-Height Conversion Sequencer

This block runs the digital side of a single-slope (run-down) pulse-height measurement. An external analog front end holds the peak of a detector pulse on a capacitor and bleeds it off at a constant rate. A comparator stays high while the held voltage is above ground. The sequencer sees two digital inputs: a pulse trigger and that comparator level. It drives one digital output, the control of the analog input switch.

When a trigger edge arrives, the block closes the switch for a short pass window so the pulse can charge the peak holder. It then opens the switch for a much longer hold window. During the hold, later pulses cannot disturb the measurement, and the block counts clock cycles while the comparator is high. When the hold ends, the count is published as an 8-bit channel number with a one-cycle valid strobe. The block then goes back to waiting for a trigger. Downstream logic can histogram the channel numbers to build a pulse-height spectrum.

Both window lengths are parameters given in clock cycles. The defaults assume a 250 MHz clock: 25,000 cycles (100 µs) for the pass window and 500,000 cycles (2 ms) for the hold window.

Top module: `wadc_conv_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, and after it, `sw_close`, `chan_valid`, `chan_ovf` and `chan_out` are all 0 and the block waits for a trigger.
- R2: `trig_in` passes through two synchronizer flops and then an edge detector. A low-to-high change on `trig_in` sampled at edge k makes `sw_close` go to 1 after edge k+2 (the pass window). `sw_close` then stays at 1 for exactly `PASS_CYC` clock cycles.
- R3: When the pass window ends, `sw_close` returns to 0 and the hold window lasts `HOLD_CYC` cycles, followed by one result cycle. Trigger edges that arrive during the pass window, the hold window or the result cycle are ignored and start no conversion.
- R4: A trigger held high for any length of time starts exactly one conversion. A new conversion needs `trig_in` to go low and then high again while the block is idle.
- R5: `cmp_in` passes through two synchronizer flops. The result equals the number of hold-window cycles in which the synchronized comparator was high. A comparator that is high while idle or during the pass window adds nothing. The counter is made of two cascaded 4-bit stages, and the low stage carries into the high stage.
- R6: If the comparator is still high when the count is 255, the count stays at 255 (it does not wrap), and that conversion reports `chan_ovf` = 1.
- R7: One cycle after the last hold cycle, `chan_valid` is 1 for exactly one cycle and `chan_out`/`chan_ovf` take the new result. `chan_out` and `chan_ovf` then keep that value until the next result.
- R8: The count and the overflow flag are cleared at the start of each conversion, so each result depends only on its own hold window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous pulse trigger from the discriminator |
| cmp_in | input | 1 | Asynchronous run-down comparator level (high while the held peak is above ground) |
| sw_close | output | 1 | Input switch control, 1 = switch closed (pulse passes) |
| chan_out | output | 8 | Channel number of the last conversion |
| chan_valid | output | 1 | One-cycle strobe marking a new `chan_out` |
| chan_ovf | output | 1 | Last conversion saturated at channel 255 |

## Verification
The embedded assertions take several things for granted. They assume `sw_close` can only rise the cycle after a synchronized trigger edge. They assume `cmp_in` is meaningful only during the hold window. They assume both window parameters are at least one cycle. The stimulus changes `trig_in` and `cmp_in` only on falling clock edges, and it holds comparator runs inside the hold window wherever an exact channel value is expected. Separate stimulus puts comparator activity in the idle and pass phases and sends triggers during busy phases, to show that these have no effect. The bench shortens the pass window to 6 cycles and the hold window to 300 cycles. This keeps runs short while still allowing the count to saturate past 255.

// File: rtl/wadc_pkg.sv
package wadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PASS = 2'd1,
    PH_HOLD = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/wadc_sync.sv
module wadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/wadc_phase_timer.sv
module wadc_phase_timer #(
  parameter int TMR_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);
  logic [TMR_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                remain_q <= '0;
    else if (load)          remain_q <= load_val;
    else if (remain_q != 0) remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);

  AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (!load && remain_q != '0) |=> (remain_q == $past(remain_q) - 1'b1)) // R2
    else $error("timer did not step down");

  AST_TMR_PARKED: assert property (@(posedge clk) disable iff (rst)
    (!load && remain_q == '0) |=> (remain_q == '0)) // R3
    else $error("expired timer moved without load");
endmodule

// File: rtl/wadc_chan_counter.sv
module wadc_chan_counter #(
  parameter int CNT_W   = 8,
  parameter int STAGE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             sat_hit
);
  localparam int STAGES = CNT_W / STAGE_W;

  logic at_top;
  logic step;

  assign at_top = &count;
  assign step   = en && !at_top;

  genvar si;
  generate
    for (si = 0; si < STAGES; si++) begin : g_nib
      logic [STAGE_W-1:0] nib_q;
      logic               nib_inc;
      if (si == 0) begin : g_lo
        assign nib_inc = step;
      end else begin : g_hi
        assign nib_inc = step && (&count[si*STAGE_W-1:0]);
      end
      always_ff @(posedge clk) begin
        if (rst || clr)   nib_q <= '0;
        else if (nib_inc) nib_q <= nib_q + 1'b1;
      end
      assign count[si*STAGE_W +: STAGE_W] = nib_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)       sat_hit <= 1'b0;
    else if (en && at_top) sat_hit <= 1'b1;
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!clr && en && at_top) |=> (&count)) // R6
    else $error("counter wrapped past top");

  AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(count)) // R5
    else $error("counter moved while disabled");

  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr && en && !at_top) |=> (count == $past(count) + 1'b1)) // R5
    else $error("counter carry chain misstepped");
endmodule

// File: rtl/wadc_conv_ctrl.sv
module wadc_conv_ctrl
  import wadc_pkg::*;
#(
  parameter int PASS_CYC  = 25000,
  parameter int HOLD_CYC  = 500000,
  parameter int CNT_W     = 8,
  parameter int STAGE_W   = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             cmp_in,
  output logic             sw_close,
  output logic [CNT_W-1:0] chan_out,
  output logic             chan_valid,
  output logic             chan_ovf
);
  localparam int LONGEST = (HOLD_CYC > PASS_CYC) ? HOLD_CYC : PASS_CYC;
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam logic [TMR_W-1:0] PASS_LD = TMR_W'(PASS_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_LD = TMR_W'(HOLD_CYC - 1);

  phase_t           phase_q;
  logic             trig_s, trig_d, trig_rise;
  logic             cmp_s;
  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic [CNT_W-1:0] run_cnt;
  logic             run_sat;
  logic             conv_start;

  wadc_sync #(.STAGES(SYNC_LEN)) u_trig_sync (
    .clk(clk), .rst(rst), .d_in(trig_in), .q_out(trig_s));

  wadc_sync #(.STAGES(SYNC_LEN)) u_cmp_sync (
    .clk(clk), .rst(rst), .d_in(cmp_in), .q_out(cmp_s));

  always_ff @(posedge clk) begin
    if (rst) trig_d <= 1'b0;
    else     trig_d <= trig_s;
  end
  assign trig_rise  = trig_s && !trig_d;
  assign conv_start = (phase_q == PH_IDLE) && trig_rise;

  assign tmr_load = conv_start || ((phase_q == PH_PASS) && tmr_exp);
  assign tmr_val  = (phase_q == PH_IDLE) ? PASS_LD : HOLD_LD;

  wadc_phase_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp));

  wadc_chan_counter #(.CNT_W(CNT_W), .STAGE_W(STAGE_W)) u_count (
    .clk(clk), .rst(rst), .clr(conv_start),
    .en((phase_q == PH_HOLD) && cmp_s),
    .count(run_cnt), .sat_hit(run_sat));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      sw_close   <= 1'b0;
      chan_valid <= 1'b0;
      chan_out   <= '0;
      chan_ovf   <= 1'b0;
    end else begin
      chan_valid <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (trig_rise) begin
          phase_q  <= PH_PASS;
          sw_close <= 1'b1;
        end
        PH_PASS: if (tmr_exp) begin
          phase_q  <= PH_HOLD;
          sw_close <= 1'b0;
        end
        PH_HOLD: if (tmr_exp) phase_q <= PH_DONE;
        PH_DONE: begin
          chan_out   <= run_cnt;
          chan_ovf   <= run_sat;
          chan_valid <= 1'b1;
          phase_q    <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_SW_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_close) |-> $past(trig_rise)) // R2
    else $error("switch closed without trigger edge");

  AST_HOLD_KEEPS_OPEN: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD) |=> !sw_close) // R3
    else $error("switch closed during hold");

  AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    chan_valid |=> !chan_valid) // R7
    else $error("valid strobe longer than one cycle");

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !chan_valid |=> (chan_valid || $stable(chan_out))) // R7
    else $error("result changed without strobe");

  AST_OVF_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (chan_valid && chan_ovf) |-> (&chan_out)) // R6
    else $error("overflow reported below top channel");
endmodule

// File: tb/wadc_conv_ctrl_tb.sv
`timescale 1ns/1ps
module wadc_conv_ctrl_tb;
  localparam int PASS_CYC = 6;
  localparam int HOLD_CYC = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_in = 1'b0;
  logic       cmp_in = 1'b0;
  logic       sw_close;
  logic [7:0] chan_out;
  logic       chan_valid;
  logic       chan_ovf;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  wadc_conv_ctrl #(.PASS_CYC(PASS_CYC), .HOLD_CYC(HOLD_CYC)) u_dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cmp_in(cmp_in),
    .sw_close(sw_close), .chan_out(chan_out),
    .chan_valid(chan_valid), .chan_ovf(chan_ovf));

  always #2 clk = ~clk;

  // Behavioural reference: input history as integers, phase tracked by elapsed cycles
  int m_trig_hist[3];
  int m_cmp_hist[2];
  int m_phase = 0;     // 0 wait, 1 pass, 2 hold, 3 publish
  int m_elapsed = 0;
  int m_tally = 0;
  int m_over = 0;
  int m_sw = 0, m_valid = 0, m_out = 0, m_ovf = 0;

  always @(posedge clk) begin
    int edge_seen, cmp_now;
    cyc++;
    if (rst) begin
      m_trig_hist = '{0, 0, 0};
      m_cmp_hist  = '{0, 0};
      m_phase = 0; m_elapsed = 0; m_tally = 0; m_over = 0;
      m_sw = 0; m_valid = 0; m_out = 0; m_ovf = 0;
    end else begin
      edge_seen = (m_trig_hist[1] == 1 && m_trig_hist[2] == 0);
      cmp_now   = m_cmp_hist[1];
      m_valid = 0;
      if (m_phase == 0) begin
        if (edge_seen) begin
          m_phase = 1; m_elapsed = 0; m_sw = 1; m_tally = 0; m_over = 0;
        end
      end else if (m_phase == 1) begin
        m_elapsed++;
        if (m_elapsed == PASS_CYC) begin m_phase = 2; m_elapsed = 0; m_sw = 0; end
      end else if (m_phase == 2) begin
        if (cmp_now == 1) begin
          if (m_tally == 255) m_over = 1;
          else m_tally++;
        end
        m_elapsed++;
        if (m_elapsed == HOLD_CYC) m_phase = 3;
      end else begin
        m_out = m_tally; m_ovf = m_over; m_valid = 1; m_phase = 0;
      end
      m_trig_hist[2] = m_trig_hist[1];
      m_trig_hist[1] = m_trig_hist[0];
      m_trig_hist[0] = int'(trig_in);
      m_cmp_hist[1] = m_cmp_hist[0];
      m_cmp_hist[0] = int'(cmp_in);
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    n_vec++;
    if (int'(sw_close) != m_sw) begin
      n_bad++; $display("FAIL R2/R3 sw_close actual=%0d expected=%0d cycle %0d", sw_close, m_sw, cyc);
    end
    if (int'(chan_valid) != m_valid) begin
      n_bad++; $display("FAIL R7 chan_valid actual=%0d expected=%0d cycle %0d", chan_valid, m_valid, cyc);
    end
    if (int'(chan_out) != m_out) begin
      n_bad++; $display("FAIL R5 chan_out actual=%0d expected=%0d cycle %0d", chan_out, m_out, cyc);
    end
    if (int'(chan_ovf) != m_ovf) begin
      n_bad++; $display("FAIL R6 chan_ovf actual=%0d expected=%0d cycle %0d", chan_ovf, m_ovf, cyc);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    ticks(3);
    trig_in = 1'b0;
  endtask

  task automatic wait_switch_open();
    @(negedge clk);
    while (!sw_close) @(negedge clk);
    while (sw_close) @(negedge clk);
  endtask

  task automatic wait_result(output int val, output int ovf);
    while (!chan_valid) @(negedge clk);
    val = int'(chan_out);
    ovf = int'(chan_ovf);
  endtask

  task automatic run_exact(input int n, input string req);
    int v, o;
    pulse_trig();
    wait_switch_open();
    ticks(3);
    cmp_in = 1'b1;
    ticks(n);
    cmp_in = 1'b0;
    wait_result(v, o);
    check({req, " channel"}, v, n);
    check({req, " overflow"}, o, 0);
    ticks(4);
  endtask

  initial begin
    int v, o;
    int seen_close;
    ticks(3);
    // R1: reset state
    check("R1 sw_close", int'(sw_close), 0);
    check("R1 chan_valid", int'(chan_valid), 0);
    check("R1 chan_out", int'(chan_out), 0);
    check("R1 chan_ovf", int'(chan_ovf), 0);
    rst = 1'b0;
    ticks(3);

    // R2: switch closes after sync latency and stays closed PASS_CYC cycles
    @(negedge clk); trig_in = 1'b1;
    ticks(2);
    check("R2 switch still open before sync", int'(sw_close), 0);
    ticks(1);
    check("R2 switch closed after edge", int'(sw_close), 1);
    ticks(PASS_CYC - 1);
    check("R2 switch closed at end of pass", int'(sw_close), 1);
    ticks(1);
    check("R3 switch opened for hold", int'(sw_close), 0);
    // R4: trigger stays high throughout; only one conversion
    wait_result(v, o);
    check("R5 no comparator gives zero", v, 0);
    ticks(1);
    check("R7 strobe lasts one cycle", int'(chan_valid), 0);
    seen_close = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sw_close) seen_close = 1;
    end
    check("R4 held trigger no restart", seen_close, 0);
    trig_in = 1'b0;
    ticks(4);

    // R5: exact counts across the nibble carry
    run_exact(20, "R5 twenty");
    run_exact(37, "R5 thirtyseven");
    run_exact(16, "R5 carry into upper stage");

    // R5: comparator high in idle and pass only -> two cycles leak through sync
    cmp_in = 1'b1;
    ticks(5);
    pulse_trig();
    wait_switch_open();
    cmp_in = 1'b0;
    wait_result(v, o);
    check("R5 idle/pass comparator ignored", v, 2);

    // R6: comparator high whole hold saturates
    ticks(3);
    cmp_in = 1'b1;
    pulse_trig();
    wait_switch_open();
    // R3: trigger during hold ignored
    ticks(10);
    pulse_trig();
    wait_result(v, o);
    cmp_in = 1'b0;
    check("R6 saturated channel", v, 255);
    check("R6 overflow flag", o, 1);
    ticks(1);
    check("R7 result held after strobe", int'(chan_out), 255);
    seen_close = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sw_close) seen_close = 1;
    end
    check("R3 hold-time trigger ignored", seen_close, 0);

    // R8: next conversion starts from zero
    run_exact(5, "R8 cleared count");

    ticks(5);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule